// File: doc/BRIEF.md
# Pixel Output Port Demultiplexer

This block takes one sampled pixel per clock and places it on a pixel output bus. A pixel holds three colour channels of 8 bits each. The block has two output ports, A and B. In single-port mode every pixel goes to port A, and port B's enable is held low so that the pins can float. In dual-port mode the pixels are split between the two ports, one port after the other. Dual-port mode comes in two forms. In interleaved form, each port takes its pixel as soon as the pixel arrives. In parallel form, a pair of pixels is held back so that both ports change in the same cycle.

A one-cycle marker on `sync_lead` tells the block that a horizontal sync leading edge has arrived. The marker does two things. First, it loads the mode inputs into the active mode register, and a mode takes effect only at this point. Second, it re-anchors the A/B alternation: the first pixel after the marker goes to port A, or to port B when the swap bit is set. A strobe output gives the downstream logic a data-clock reference. A valid flag stays low until the pipeline has filled, so that the leading output sets are masked.

The controller is a three-state machine:
- `ST_SINGLE` is single-port mode.
- `ST_LEAD` takes the first pixel of a pair.
- `ST_TRAIL` takes the second pixel of a pair.

The transitions are as follows:
- *anchor*: a sync marker moves the machine to `ST_LEAD` when the new mode is dual, or to `ST_SINGLE` otherwise.
- *advance*: without a marker, the machine moves from `ST_LEAD` to `ST_TRAIL`.
- *wrap*: without a marker, the machine moves from `ST_TRAIL` to `ST_LEAD`.
- *stay*: without a marker, `ST_SINGLE` holds.

Top module: `pixel_port_demux`

## Requirements
- R1: While `rst_n` is low and after its release, before the first clock edge with reset high: `port_a` and `port_b` are 0, `oe_a` is 1, `oe_b` is 0, `dstrobe` is 1 and `data_ok` is 0. The active mode after reset is single-port, interleaved, no swap.
- R2: Single-port mode (`cfg_dual`=0). The pixel that is on `pix_in` at a rising edge appears on `port_a` directly after that edge. `oe_b` stays 0 in this mode.
- R3: Dual interleaved mode (`cfg_dual`=1, `cfg_par`=0). The pixel taken in `ST_LEAD` or `ST_TRAIL` is written to its own port directly after the edge, and the other port holds its value. `oe_b` is 1 in this mode.
- R4: Dual parallel mode (`cfg_par`=1). Neither port changes on the edge of an `ST_LEAD` pixel. On the edge of the following `ST_TRAIL` pixel, the lead-side port takes the held lead pixel and the trail-side port takes the trail pixel, both at once.
- R5: With `cfg_swap`=0 at the sync marker, the pixel in the cycle after the marker goes to port A and the next pixel goes to port B.
- R6: With `cfg_swap`=1 at the sync marker, the first pixel after the marker goes to port B and the second goes to port A.
- R7: A change on `cfg_dual`, `cfg_par` or `cfg_swap` has no effect until a clock edge where `sync_lead` is 1. At that edge the new mode is loaded.
- R8: Whenever the pixel that wrote `port_a` was taken in a dual-mode state, `dstrobe` is 0 while `port_a` shows that new value. Otherwise `dstrobe` is 1, so it is constantly 1 in single-port mode. Because `port_a` changes every second pixel in dual mode, the rising edge of `dstrobe` falls midway between `port_a` changes.
- R9: An output set is one pixel in single-port mode, and one completed `ST_TRAIL` pixel in dual mode. In single-port mode `data_ok` is 0 for the first 4 output sets and 1 from the 5th set onward.
- R10: In dual mode `data_ok` is 0 for the first 2 output sets and 1 from the 3rd set onward.
- R11: A sync marker that loads a mode different from the active one clears `data_ok` and restarts the set count. A marker that loads the same mode leaves the count and `data_ok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 24 | Sampled pixel, three 8-bit channels |
| sync_lead | input | 1 | One-cycle marker for a sync leading edge |
| cfg_dual | input | 1 | 1 selects dual-port mode |
| cfg_par | input | 1 | In dual-port mode, 1 selects parallel form and 0 selects interleaved form |
| cfg_swap | input | 1 | 1 makes the first pixel after sync go to port B |
| port_a | output | 24 | Port A pixel data |
| port_b | output | 24 | Port B pixel data |
| oe_a | output | 1 | Port A output enable |
| oe_b | output | 1 | Port B output enable (0 models high impedance) |
| dstrobe | output | 1 | Data-clock reference |
| data_ok | output | 1 | Output set is past the startup flush |

## Verification
The bench builds the block with its default parameters: three 8-bit channels, and 4 and 2 masked sets in single and dual mode. These small set counts keep the flush boundaries within a few cycles of every mode change. Random sync spacing, including markers only a few pixels apart, lands re-anchoring on both `ST_LEAD` and `ST_TRAIL`. Mode bits that change between markers exercise the deferred loading. Some markers reload the same mode, which shows that the set count survives them.

// File: rtl/pixel_port_demux_pkg.sv
package pixel_port_demux_pkg;

    typedef enum logic [1:0] {
        ST_SINGLE = 2'd0,
        ST_LEAD   = 2'd1,
        ST_TRAIL  = 2'd2
    } phase_t;

    typedef struct packed {
        logic dual;
        logic par;
        logic swap;
    } mode_t;

endpackage

// File: rtl/pixel_port_demux_ctrl.sv
module pixel_port_demux_ctrl
    import pixel_port_demux_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_lead,
    input  mode_t  cfg,
    output mode_t  act,
    output logic   mode_chg,
    output logic   wr_a,
    output logic   wr_b,
    output logic   a_from_hold,
    output logic   b_from_hold,
    output logic   hold_en,
    output logic   set_evt
);

    phase_t state, state_nxt;

    assign mode_chg = sync_lead && (cfg != act);

    // state register and active mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SINGLE;
            act   <= '0;
        end else begin
            state <= state_nxt;
            if (sync_lead) act <= cfg;
        end
    end

    // next state and per-pixel routing
    always_comb begin
        state_nxt   = state;
        wr_a        = 1'b0;
        wr_b        = 1'b0;
        a_from_hold = 1'b0;
        b_from_hold = 1'b0;
        hold_en     = 1'b0;
        set_evt     = 1'b0;
        unique case (state)
            ST_SINGLE: begin
                wr_a      = 1'b1;
                set_evt   = 1'b1;
                state_nxt = ST_SINGLE;
            end
            ST_LEAD: begin
                if (act.par) hold_en = 1'b1;
                else if (act.swap) wr_b = 1'b1;
                else wr_a = 1'b1;
                state_nxt = ST_TRAIL;
            end
            ST_TRAIL: begin
                set_evt = 1'b1;
                if (act.par) begin
                    wr_a        = 1'b1;
                    wr_b        = 1'b1;
                    a_from_hold = !act.swap;
                    b_from_hold = act.swap;
                end else if (act.swap) begin
                    wr_a = 1'b1;
                end else begin
                    wr_b = 1'b1;
                end
                state_nxt = ST_LEAD;
            end
            default: state_nxt = ST_SINGLE;
        endcase
        if (sync_lead) state_nxt = cfg.dual ? ST_LEAD : ST_SINGLE;
    end

    assert_anchor_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lead && cfg.dual) |=> (state == ST_LEAD));
    assert_anchor_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lead && !cfg.dual) |=> (state == ST_SINGLE));
    assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_lead && state == ST_LEAD) |=> (state == ST_TRAIL));
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lead |=> $stable(act));

endmodule

// File: rtl/pixel_port_demux_path.sv
module pixel_port_demux_path #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             dual,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic             a_from_hold,
    input  logic             b_from_hold,
    input  logic             hold_en,
    output logic [PIX_W-1:0] port_a,
    output logic [PIX_W-1:0] port_b,
    output logic             dstrobe
);

    logic [PIX_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            port_a  <= '0;
            port_b  <= '0;
            dstrobe <= 1'b1;
        end else begin
            if (hold_en) hold_q <= pix_in;
            if (wr_a) port_a <= a_from_hold ? hold_q : pix_in;
            if (wr_b) port_b <= b_from_hold ? hold_q : pix_in;
            dstrobe <= dual ? !wr_a : 1'b1;
        end
    end

    assert_parallel_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_from_hold || b_from_hold) |-> (wr_a && wr_b));
    assert_strobe_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dstrobe |-> !$stable(port_a) || $past(wr_a));

endmodule

// File: rtl/pixel_port_demux_valid.sv
module pixel_port_demux_valid #(
    parameter int SKIP_SINGLE = 4,
    parameter int SKIP_DUAL   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dual,
    input  logic set_evt,
    input  logic mode_chg,
    output logic data_ok
);

    localparam int SKIP_MAX = (SKIP_SINGLE > SKIP_DUAL) ? SKIP_SINGLE : SKIP_DUAL;
    localparam int CW       = $clog2(SKIP_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] skip;

    assign skip = dual ? CW'(SKIP_DUAL) : CW'(SKIP_SINGLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            data_ok <= 1'b0;
        end else if (mode_chg) begin
            cnt     <= '0;
            data_ok <= 1'b0;
        end else if (set_evt) begin
            if (cnt >= skip) begin
                data_ok <= 1'b1;
            end else begin
                data_ok <= 1'b0;
                cnt     <= cnt + 1'b1;
            end
        end
    end

    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ok && !mode_chg) |=> data_ok);
    assert_flush_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !data_ok);

endmodule

// File: rtl/pixel_port_demux.sv
module pixel_port_demux
    import pixel_port_demux_pkg::*;
#(
    parameter int CH_W        = 8,
    parameter int CH_N        = 3,
    parameter int SKIP_SINGLE = 4,
    parameter int SKIP_DUAL   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CH_W*CH_N-1:0] pix_in,
    input  logic                 sync_lead,
    input  logic                 cfg_dual,
    input  logic                 cfg_par,
    input  logic                 cfg_swap,
    output logic [CH_W*CH_N-1:0] port_a,
    output logic [CH_W*CH_N-1:0] port_b,
    output logic                 oe_a,
    output logic                 oe_b,
    output logic                 dstrobe,
    output logic                 data_ok
);

    localparam int PIX_W = CH_W * CH_N;

    mode_t cfg, act;
    logic  mode_chg, wr_a, wr_b, a_from_hold, b_from_hold, hold_en, set_evt;

    assign cfg  = '{dual: cfg_dual, par: cfg_par, swap: cfg_swap};
    assign oe_a = 1'b1;
    assign oe_b = act.dual;

    pixel_port_demux_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_lead(sync_lead), .cfg(cfg),
        .act(act), .mode_chg(mode_chg), .wr_a(wr_a), .wr_b(wr_b),
        .a_from_hold(a_from_hold), .b_from_hold(b_from_hold),
        .hold_en(hold_en), .set_evt(set_evt)
    );

    pixel_port_demux_path #(.PIX_W(PIX_W)) u_path (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .dual(act.dual),
        .wr_a(wr_a), .wr_b(wr_b), .a_from_hold(a_from_hold),
        .b_from_hold(b_from_hold), .hold_en(hold_en),
        .port_a(port_a), .port_b(port_b), .dstrobe(dstrobe)
    );

    pixel_port_demux_valid #(.SKIP_SINGLE(SKIP_SINGLE), .SKIP_DUAL(SKIP_DUAL)) u_valid (
        .clk(clk), .rst_n(rst_n), .dual(act.dual), .set_evt(set_evt),
        .mode_chg(mode_chg), .data_ok(data_ok)
    );

endmodule

// File: tb/pixel_port_demux_tb.sv
module pixel_port_demux_tb;

    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pix_in = '0;
    logic          sync_lead = 1'b0;
    logic          cfg_dual = 1'b0, cfg_par = 1'b0, cfg_swap = 1'b0;
    logic [PW-1:0] port_a, port_b;
    logic          oe_a, oe_b, dstrobe, data_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic          m_dual = 0, m_par = 0, m_swap = 0;
    int            m_ph = 0;
    logic [PW-1:0] m_hold = '0, m_a = '0, m_b = '0;
    logic          m_strb = 1'b1, m_ok = 1'b0;
    int            m_cnt = 0;

    always #5 clk = ~clk;

    pixel_port_demux u_dut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .sync_lead(sync_lead),
        .cfg_dual(cfg_dual), .cfg_par(cfg_par), .cfg_swap(cfg_swap),
        .port_a(port_a), .port_b(port_b), .oe_a(oe_a), .oe_b(oe_b),
        .dstrobe(dstrobe), .data_ok(data_ok)
    );

    function automatic int skip_of(logic dual);
        return dual ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dual = 0; m_par = 0; m_swap = 0; m_ph = 0;
            m_hold = '0; m_a = '0; m_b = '0; m_strb = 1; m_ok = 0; m_cnt = 0;
        end else begin
            logic wa;
            logic se;
            wa = 0; se = 0;
            if (m_ph == 0) begin
                m_a = pix_in; wa = 1; se = 1;
            end else if (m_ph == 1) begin
                if (m_par) m_hold = pix_in;
                else if (m_swap) m_b = pix_in;
                else begin m_a = pix_in; wa = 1; end
            end else begin
                se = 1;
                if (m_par) begin
                    wa = 1;
                    if (m_swap) begin m_a = pix_in; m_b = m_hold; end
                    else begin m_a = m_hold; m_b = pix_in; end
                end else if (m_swap) begin
                    m_a = pix_in; wa = 1;
                end else m_b = pix_in;
            end
            m_strb = m_dual ? !wa : 1'b1;
            if (se) begin
                if (m_cnt >= skip_of(m_dual)) m_ok = 1;
                else begin m_ok = 0; m_cnt++; end
            end
            if (sync_lead) begin
                if ({cfg_dual, cfg_par, cfg_swap} != {m_dual, m_par, m_swap}) begin
                    m_cnt = 0; m_ok = 0;
                end
                m_dual = cfg_dual; m_par = cfg_par; m_swap = cfg_swap;
                m_ph = cfg_dual ? 1 : 0;
            end else if (m_ph == 1) m_ph = 2;
            else if (m_ph == 2) m_ph = 1;
        end
    end

    task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        string dtag;
        dtag = !m_dual ? "R2" : (m_par ? "R4" : "R3");
        chk(dtag, port_a, m_a);
        if (m_dual) chk(dtag, port_b, m_b);
        chk(m_dual ? "R3_oeb" : "R2_oeb", PW'(oe_b), PW'(m_dual));
        chk("R8", PW'(dstrobe), PW'(m_strb));
        chk(m_dual ? "R10" : "R9", PW'(data_ok), PW'(m_ok));
    endtask

    task automatic step(logic [PW-1:0] p, logic s);
        @(negedge clk);
        check_all();
        pix_in = p; sync_lead = s;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk("R1_a", port_a, '0);
        chk("R1_b", port_b, '0);
        chk("R1_oea", PW'(oe_a), PW'(1));
        chk("R1_oeb", PW'(oe_b), PW'(0));
        chk("R1_strb", PW'(dstrobe), PW'(1));
        chk("R1_ok", PW'(data_ok), PW'(0));
        rst_n = 1'b1;

        // R9: single-mode flush of 4 sets
        for (int i = 0; i < 8; i++) step(PW'(24'h100 + i), 1'b0);

        // R5: dual interleaved, anchored to A
        cfg_dual = 1; cfg_par = 0; cfg_swap = 0;
        step(24'h0, 1'b1);
        step(24'hA5A5A5, 1'b0);
        step(24'h5A5A5A, 1'b0);
        @(negedge clk);
        chk("R5_first_to_a", port_a, 24'hA5A5A5);
        chk("R5_second_to_b", port_b, 24'h5A5A5A);

        // R6: swap sends first pixel to B
        cfg_swap = 1;
        pix_in = 24'h0; sync_lead = 1;
        step(24'h123456, 1'b0);
        step(24'h654321, 1'b0);
        @(negedge clk);
        chk("R6_first_to_b", port_b, 24'h123456);
        chk("R6_second_to_a", port_a, 24'h654321);

        // R7: config change without sync does not alter mode
        cfg_dual = 0; cfg_par = 1; cfg_swap = 0;
        pix_in = 24'h0; sync_lead = 0;
        for (int i = 0; i < 6; i++) step(PW'(24'h200 + i), 1'b0);
        @(negedge clk);
        chk("R7_oeb_kept", PW'(oe_b), PW'(1));

        // R11: same-mode sync keeps data_ok; then parallel mode (R4)
        cfg_dual = 1; cfg_par = 0; cfg_swap = 1;
        step(24'h0, 1'b1);
        step(24'h1, 1'b0);
        @(negedge clk);
        chk("R11_same_mode", PW'(data_ok), PW'(1));
        cfg_par = 1; cfg_swap = 0;
        pix_in = 24'h0; sync_lead = 1;
        for (int i = 0; i < 10; i++) step(PW'(24'h300 + i), 1'b0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic s;
            s = ($urandom % 23) == 0;
            if (($urandom % 37) == 0) begin
                cfg_dual = $urandom; cfg_par = $urandom; cfg_swap = $urandom;
            end
            step(PW'($urandom), s);
        end
        step(24'h0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule